// File: doc/BRIEF.md
# One-Time-Programmable Fuse Command Front-End

This block sits between a CPU register port and a one-time-programmable fuse array. Software fills a handful of registers: an access-control word, a row number and two write-data words. It then raises a start bit together with a command code, polls for completion and reads back the result. The fuse array is modelled inside the block as 2**ROW_AW rows of 41 bits each: 32 data bits plus 9 check bits. After reset the model clears every row, one per cycle, before it reports ready.

Programming is guarded. A word-program command changes the array only after a fixed four-value key has gone through four separately started program-enable commands. It also needs the CPU-access bit to stay set the whole time. Programming can only add ones to a row. Reads return the full 41-bit row. A read also raises an error flag when the row's top check bit is blown, unless checking has been switched off.

Registers are 32 bits wide and sit at byte offsets on a 6-bit address, with accesses aligned to words:

| Offset | Register |
|---|---|
| 0x00 | command |
| 0x04 | access control |
| 0x08 | row address |
| 0x0C | write-data low |
| 0x10 | write-data high |
| 0x14 | status 0 |
| 0x18 | status 1 |
| 0x1C | read-data low |
| 0x20 | read-data high |

Top module: `otpfe_top`

## Requirements
- R1: After reset, status 0 bit 3 (ready) reads 0 until every row has been cleared, and then reads 1. Every row then reads back as zero.
- R2: A command launches only while access-control bit 15 (CPU access) is 1 and ready is 1. Otherwise command-done never sets.
- R3: In the command register, bit 0 is start and bits 4:1 hold the code: 0 read, 2 program-enable, 10 program-word. A start that stays at 1 launches once. Start must return to 0 before another launch.
- R4: Status 1 bit 1 (command-done) reads 1 from the (LAT+1)-th rising edge after the write that sets start, and reads 0 before that edge. Writing 1 to the bit clears it. If the clear lands on the same edge as a completion, the completion wins.
- R5: A read uses the row number in bits 15:6 of the row-address register. Read-data low receives row bits 31:0. Read-data high bits 8:0 receive row bits 40:32.
- R6: Each completed read sets status 1 bit 17 (check error) to row bit 40 AND NOT access-control bit 9 (check disable).
- R7: Status 0 bit 2 (program-OK) sets after four program-enable commands whose write-data low values are 0xF, 0x4, 0x8 and 0xD, in that order.
- R8: A program-enable command carrying a value other than the one expected next resets the unlock progress to the first key.
- R9: Clearing access-control bit 15 drops program-OK and the unlock progress.
- R10: A program-word command without program-OK still sets command-done, but leaves the array unchanged.
- R11: A program-word command with program-OK ORs write-data low into row bits 31:0. It ORs write-data high bits 8:0 into row bits 40:32 only when access-control bit 8 (check-write enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bus_sel | input | 1 | register access strobe |
| bus_we | input | 1 | write when 1 with bus_sel |
| bus_addr | input | 6 | byte offset, bits 1:0 must be 0 |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr, combinational |

## Verification
Two things can land on the same edge: the completion that sets command-done, and a software write-1-to-clear of that bit. The bench times a clear so that it hits the exact completion edge, counted from the start write, and expects command-done to read 1 afterwards. It then issues a clear one edge later and expects 0. Random program and read rows are checked against an OR-accumulating bench model for both check-write settings and both check-disable settings.

// File: rtl/otpfe_pkg.sv
package otpfe_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 9;
  localparam int ROW_W  = DATA_W + CHK_W;

  localparam logic [3:0] RA_CMD  = 4'd0;
  localparam logic [3:0] RA_ACC  = 4'd1;
  localparam logic [3:0] RA_ROW  = 4'd2;
  localparam logic [3:0] RA_WLO  = 4'd3;
  localparam logic [3:0] RA_WHI  = 4'd4;
  localparam logic [3:0] RA_ST0  = 4'd5;
  localparam logic [3:0] RA_ST1  = 4'd6;
  localparam logic [3:0] RA_RLO  = 4'd7;
  localparam logic [3:0] RA_RHI  = 4'd8;

  localparam int ACC_CPU    = 15;
  localparam int ACC_CHKOFF = 9;
  localparam int ACC_CHKWEN = 8;
  localparam int ROW_LSB    = 6;
  localparam int ST1_DONE   = 1;

  localparam logic [3:0] OP_READ  = 4'd0;
  localparam logic [3:0] OP_PEN   = 4'd2;
  localparam logic [3:0] OP_PWORD = 4'd10;

  typedef enum logic {SQ_IDLE, SQ_RUN} seq_state_e;

  function automatic logic [DATA_W-1:0] unlock_key(input logic [1:0] idx);
    case (idx)
      2'd0:    return 32'h0000_000F;
      2'd1:    return 32'h0000_0004;
      2'd2:    return 32'h0000_0008;
      default: return 32'h0000_000D;
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] fuse_merge(input logic [ROW_W-1:0] old,
                                                  input logic [DATA_W-1:0] lo,
                                                  input logic [CHK_W-1:0] hi,
                                                  input logic wen);
    return old | {(wen ? hi : {CHK_W{1'b0}}), lo};
  endfunction

  function automatic logic chk_flag(input logic [ROW_W-1:0] row, input logic off);
    return row[ROW_W-1] & ~off;
  endfunction
endpackage

// File: rtl/otpfe_seq.sv
module otpfe_seq
  import otpfe_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] code,
  input  logic       cpu_en,
  input  logic       ready,
  output logic       busy,
  output logic       finish,
  output logic [3:0] fin_code
);
  localparam int CW = $clog2(LAT + 1);

  seq_state_e      state;
  logic [CW-1:0]   cnt;
  logic            armed;
  logic            launch;

  assign launch   = start & armed & (state == SQ_IDLE) & cpu_en & ready;
  assign busy     = (state == SQ_RUN);
  assign finish   = busy && (cnt == CW'(LAT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      armed    <= 1'b1;
      fin_code <= '0;
    end else begin
      if (!start)      armed <= 1'b1;
      else if (launch) armed <= 1'b0;
      case (state)
        SQ_IDLE: if (launch) begin
          state    <= SQ_RUN;
          cnt      <= '0;
          fin_code <= code;
        end
        default: if (finish) state <= SQ_IDLE;
                 else        cnt   <= cnt + 1'b1;
      endcase
    end
  end

  // R2: a command only starts when access and ready were present
  p_launch_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cpu_en) && $past(ready)));
  // R3: a held start cannot relaunch right after a completion
  p_no_relaunch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && start && $past(start)) |=> !busy);
  // R4: completion is a single-cycle event
  p_finish_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);
endmodule

// File: rtl/otpfe_unlock.sv
module otpfe_unlock
  import otpfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              pen_done,
  input  logic [DATA_W-1:0] key,
  output logic              prog_ok
);
  logic [1:0] step;
  logic       key_hit;

  assign key_hit = (key == unlock_key(step));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= '0;
      prog_ok <= 1'b0;
    end else if (!cpu_en) begin
      step    <= '0;
      prog_ok <= 1'b0;
    end else if (pen_done && !prog_ok) begin
      if (!key_hit)          step <= '0;
      else if (step == 2'd3) begin
        prog_ok <= 1'b1;
        step    <= '0;
      end else               step <= step + 1'b1;
    end
  end

  // R9: dropping access always removes the unlock
  p_drop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |=> !prog_ok);
  // R7: unlock completes only on a program-enable carrying the last key
  p_ok_on_last_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ok) |-> ($past(pen_done) && ($past(key) == 32'h0000_000D)));
endmodule

// File: rtl/otpfe_array.sv
module otpfe_array
  import otpfe_pkg::*;
#(
  parameter int ROW_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_AW-1:0] addr,
  input  logic [ROW_W-1:0]  wdata,
  output logic [ROW_W-1:0]  rdata,
  output logic              ready
);
  localparam int ROWS = 1 << ROW_AW;

  logic [ROW_W-1:0]  mem [ROWS];
  logic [ROW_AW-1:0] init_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_ptr <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      if (init_ptr == ROW_AW'(ROWS - 1)) ready <= 1'b1;
      else                               init_ptr <= init_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!ready)  mem[init_ptr] <= '0;
    else if (we) mem[addr]     <= wdata;
  end

  assign rdata = mem[addr];

  // R11: a program may only add ones to a row
  p_bits_only_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ready) |-> ((wdata & mem[addr]) == mem[addr]));
  // R1: nothing is programmed while the array is still being cleared
  p_no_write_in_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !we);
endmodule

// File: rtl/otpfe_top.sv
module otpfe_top
  import otpfe_pkg::*;
#(
  parameter int ROW_AW = 10,
  parameter int LAT    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic              start_q;
  logic [3:0]        code_q;
  logic              cpu_en, chk_off, chk_wen;
  logic [ROW_AW-1:0] row_q;
  logic [DATA_W-1:0] wlo_q, rlo_q;
  logic [CHK_W-1:0]  whi_q, rhi_q;
  logic              done_q, chk_q;

  logic              aligned, wr;
  logic [3:0]        idx;
  logic              busy, finish, ready, prog_ok;
  logic [3:0]        fin_code;
  logic              rd_done, pen_done, pw_done, arr_we;
  logic [ROW_W-1:0]  arr_rdata, arr_wdata;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign idx      = bus_addr[5:2];
  assign wr       = bus_sel & bus_we & aligned;
  assign rd_done  = finish && (fin_code == OP_READ);
  assign pen_done = finish && (fin_code == OP_PEN);
  assign pw_done  = finish && (fin_code == OP_PWORD);
  assign arr_we   = pw_done && prog_ok;
  assign arr_wdata = fuse_merge(arr_rdata, wlo_q, whi_q, chk_wen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0; code_q <= '0;
      cpu_en  <= 1'b0; chk_off <= 1'b0; chk_wen <= 1'b0;
      row_q   <= '0; wlo_q <= '0; whi_q <= '0;
    end else if (wr) begin
      case (idx)
        RA_CMD: begin start_q <= bus_wdata[0]; code_q <= bus_wdata[4:1]; end
        RA_ACC: begin
          cpu_en  <= bus_wdata[ACC_CPU];
          chk_off <= bus_wdata[ACC_CHKOFF];
          chk_wen <= bus_wdata[ACC_CHKWEN];
        end
        RA_ROW: row_q <= bus_wdata[ROW_LSB +: ROW_AW];
        RA_WLO: wlo_q <= bus_wdata;
        RA_WHI: whi_q <= bus_wdata[CHK_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; chk_q <= 1'b0; rlo_q <= '0; rhi_q <= '0;
    end else begin
      if (finish) done_q <= 1'b1;
      else if (wr && idx == RA_ST1 && bus_wdata[ST1_DONE]) done_q <= 1'b0;
      if (rd_done) begin
        rlo_q <= arr_rdata[DATA_W-1:0];
        rhi_q <= arr_rdata[ROW_W-1:DATA_W];
        chk_q <= chk_flag(arr_rdata, chk_off);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        RA_CMD: bus_rdata = {27'b0, code_q, start_q};
        RA_ACC: bus_rdata = {16'b0, cpu_en, 5'b0, chk_off, chk_wen, 8'b0};
        RA_ROW: bus_rdata = 32'(row_q) << ROW_LSB;
        RA_WLO: bus_rdata = wlo_q;
        RA_WHI: bus_rdata = 32'(whi_q);
        RA_ST0: bus_rdata = {28'b0, ready, prog_ok, 2'b0};
        RA_ST1: bus_rdata = {14'b0, chk_q, 15'b0, done_q, 1'b0};
        RA_RLO: bus_rdata = rlo_q;
        RA_RHI: bus_rdata = 32'(rhi_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  otpfe_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_q), .code(code_q),
    .cpu_en(cpu_en), .ready(ready), .busy(busy), .finish(finish),
    .fin_code(fin_code)
  );

  otpfe_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .pen_done(pen_done),
    .key(wlo_q), .prog_ok(prog_ok)
  );

  otpfe_array #(.ROW_AW(ROW_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .addr(row_q),
    .wdata(arr_wdata), .rdata(arr_rdata), .ready(ready)
  );

  // R4: every completion leaves command-done set, even against a clear
  p_done_after_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_q);
  // R10: a refused program leaves the addressed row untouched
  p_refused_keeps_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_done && !prog_ok && !(wr && idx == RA_ROW)) |=> $stable(arr_rdata));
  // R6: with checking disabled a read never flags an error
  p_chk_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && chk_off) |=> !chk_q);
  // R2: no completion without a prior busy period
  p_finish_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> busy);
endmodule

// File: tb/tb_otpfe_top.sv
module tb_otpfe_top;
  localparam int ROW_AW = 10;
  localparam int LAT    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [40:0] mdl [16];

  always #5 clk = ~clk;

  otpfe_top #(.ROW_AW(ROW_AW), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  localparam logic [3:0] A_CMD = 0, A_ACC = 1, A_ROW = 2, A_WLO = 3, A_WHI = 4,
                         A_ST0 = 5, A_ST1 = 6, A_RLO = 7, A_RHI = 8;

  function automatic logic [40:0] exp_or(input logic [40:0] o, input logic [31:0] lo,
                                         input logic [8:0] hi, input bit wen);
    logic [40:0] add;
    add = {9'b0, lo};
    if (wen) add[40:32] = hi;
    return o | add;
  endfunction

  function automatic bit exp_err(input logic [40:0] r, input bit off);
    return r[40] && !off;
  endfunction

  function automatic logic [31:0] acc_word(input bit cpu, input bit off, input bit wen);
    return (cpu ? 32'h8000 : 32'h0) | (off ? 32'h200 : 32'h0) | (wen ? 32'h100 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {a, 2'b00}; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = {a, 2'b00};
    #1 d = bus_rdata;
  endtask

  task automatic run_cmd(input logic [3:0] code, output bit got_done);
    logic [31:0] s;
    got_done = 0;
    wr(A_CMD, {27'b0, code, 1'b0});
    wr(A_CMD, {27'b0, code, 1'b1});
    for (int i = 0; i < 40 && !got_done; i++) begin
      @(posedge clk); #1 rd(A_ST1, s);
      got_done = s[1];
    end
    wr(A_ST1, 32'h2);
    wr(A_CMD, {27'b0, code, 1'b0});
  endtask

  task automatic read_row(input int row, output logic [40:0] val, output bit err);
    logic [31:0] lo, hi, s;
    bit d;
    wr(A_ROW, 32'(row) << 6);
    run_cmd(4'd0, d);
    rd(A_RLO, lo); rd(A_RHI, hi); rd(A_ST1, s);
    val = {hi[8:0], lo};
    err = s[17];
  endtask

  task automatic program_row(input int row, input logic [31:0] lo, input logic [8:0] hi,
                             output bit d);
    wr(A_ROW, 32'(row) << 6);
    wr(A_WLO, lo);
    wr(A_WHI, {23'b0, hi});
    run_cmd(4'd10, d);
  endtask

  task automatic send_key(input logic [31:0] k);
    bit d;
    wr(A_WLO, k);
    run_cmd(4'd2, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [40:0] v;
    bit e, d, ready_seen;
    void'($urandom(32'd7321));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: not ready straight after reset
    rd(A_ST0, s);
    chk("R1 ready after reset", s[3], 1'b0);
    ready_seen = 0;
    for (int i = 0; i < 3000 && !ready_seen; i++) begin
      @(posedge clk); #1 rd(A_ST0, s);
      ready_seen = s[3];
    end
    chk("R1 ready after clear", ready_seen, 1'b1);

    // R2: no access bit, no command
    wr(A_ROW, 32'd5 << 6);
    wr(A_CMD, 32'h1);
    repeat (LAT + 4) @(posedge clk);
    #1 rd(A_ST1, s);
    chk("R2 done without access", s[1], 1'b0);
    wr(A_CMD, 32'h0);

    wr(A_ACC, acc_word(1, 0, 0));
    rd(A_ACC, s);
    chk("R2 access readback", s, 32'h8000);

    // R4: exact latency, R5: cleared row reads zero
    wr(A_CMD, 32'h1);
    repeat (LAT) @(posedge clk);
    #1 rd(A_ST1, s);
    chk("R4 done early", s[1], 1'b0);
    @(posedge clk);
    #1 rd(A_ST1, s);
    chk("R4 done on time", s[1], 1'b1);
    rd(A_RLO, s);
    chk("R5 R1 row zero", s, 32'h0);
    wr(A_ST1, 32'h2);
    rd(A_ST1, s);
    chk("R4 w1c clears", s[1], 1'b0);

    // R3: held start does not relaunch
    wr(A_CMD, 32'h1);
    repeat (LAT + 4) @(posedge clk);
    #1 rd(A_ST1, s);
    chk("R3 held start", s[1], 1'b0);
    wr(A_CMD, 32'h0);
    wr(A_CMD, 32'h1);
    repeat (LAT + 2) @(posedge clk);
    #1 rd(A_ST1, s);
    chk("R3 rearmed start", s[1], 1'b1);
    wr(A_ST1, 32'h2);
    wr(A_CMD, 32'h0);

    // R4: clear collides with completion, completion wins
    wr(A_CMD, 32'h1);
    repeat (LAT) @(posedge clk);
    wr(A_ST1, 32'h2);
    rd(A_ST1, s);
    chk("R4 collision keeps done", s[1], 1'b1);
    wr(A_ST1, 32'h2);
    rd(A_ST1, s);
    chk("R4 later clear", s[1], 1'b0);
    wr(A_CMD, 32'h0);

    // R10: program without unlock
    program_row(3, 32'hFFFF_0000, 9'h1FF, d);
    chk("R10 refused done", d, 1'b1);
    read_row(3, v, e);
    chk("R10 row unchanged", v, 41'h0);

    // R8: broken sequence (F,F,4,8,D)
    send_key(32'hF); send_key(32'hF); send_key(32'h4); send_key(32'h8); send_key(32'hD);
    rd(A_ST0, s);
    chk("R8 broken sequence", s[2], 1'b0);
    // R7: correct sequence
    send_key(32'hF); send_key(32'h4); send_key(32'h8); send_key(32'hD);
    rd(A_ST0, s);
    chk("R7 unlocked", s[2], 1'b1);

    // R11, R6, R5: random program and read
    for (int it = 0; it < 40; it++) begin
      int r;
      logic [31:0] lo;
      logic [8:0] hi;
      bit wen, off;
      r   = int'($urandom_range(0, 15));
      lo  = $urandom & $urandom;
      hi  = 9'($urandom);
      wen = 1'($urandom);
      off = 1'($urandom);
      wr(A_ACC, acc_word(1, off, wen));
      program_row(r, lo, hi, d);
      mdl[r] = exp_or(mdl[r], lo, hi, wen);
      read_row(r, v, e);
      chk("R11 R5 row value", v, mdl[r]);
      chk("R6 check flag", e, exp_err(mdl[r], off));
    end
    read_row(1023, v, e);
    chk("R5 last row", v, 41'h0);

    // R6: directed flag with checking on
    wr(A_ACC, acc_word(1, 0, 1));
    program_row(15, 32'h1, 9'h100, d);
    mdl[15] = exp_or(mdl[15], 32'h1, 9'h100, 1);
    read_row(15, v, e);
    chk("R6 flag set", e, 1'b1);
    wr(A_ACC, acc_word(1, 1, 1));
    read_row(15, v, e);
    chk("R6 flag disabled", e, 1'b0);

    // R9: dropping access clears unlock
    wr(A_ACC, acc_word(0, 0, 1));
    wr(A_ACC, acc_word(1, 0, 1));
    rd(A_ST0, s);
    chk("R9 unlock dropped", s[2], 1'b0);
    program_row(2, 32'hA5A5_A5A5, 9'h0FF, d);
    mdl[2] = mdl[2];
    read_row(2, v, e);
    chk("R9 R10 no program after drop", v, mdl[2]);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule